// File: doc/BRIEF.md
# Key-Guarded Register Write Filter

This block sits on a byte-wide register bus and decides, for every bus write, whether that write may reach one of a small set of protected registers. Software first writes an unlock key to a dedicated key register. The key value it writes chooses which group of protected registers opens. One key value opens the interrupt-pin configuration register and the four timekeeping registers (hundredths, seconds, minutes, hours). A second key value opens the power control register. A write that lands on a protected register without the matching key is dropped, and a one-cycle `write_rejected` pulse follows it.

An accepted timekeeping or power control write returns the key register to zero, so each such write needs a fresh key write first. A write to the interrupt-pin configuration register leaves the key in place. In this block the protected registers are plain byte stubs that hold whatever was written to them. Reads are never filtered. The bus has no back-pressure: every request is taken in the cycle it is presented, and read data comes back one cycle later.

Top module: `reg_write_guard`

## Requirements
- R1: After reset the key register, every protected register and `write_rejected` are all zero. A key of zero unlocks nothing.
- R2: A write to address 0xC1 stores `bus_wdata` in the key register, whatever the value.
- R3: While the key holds 0xEA, a write to the interrupt-pin configuration register at 0xFF is accepted, and the key keeps its value afterwards.
- R4: While the key holds 0xEA, a write to any timekeeping register (default addresses 0xA2 hundredths, 0xA3 seconds, 0xA4 minutes, 0xA5 hours) is accepted, and the key reads 0x00 from the next cycle on. A second timekeeping write without a new key write is rejected.
- R5: While the key holds 0xA7, a write to the power control register (default address 0x87) is accepted, and the key is then cleared to 0x00.
- R6: A write to a protected register whose group does not match the current key leaves that register unchanged and leaves the key unchanged. `write_rejected` is 1 in exactly the cycle after that write and 0 otherwise. For example, 0xEA does not open power control, and 0xA7 does not open the pin or timekeeping registers.
- R7: A key value other than 0xEA or 0xA7 is stored and can be read back, but it opens no protected register.
- R8: A read presented in cycle T returns the addressed register on `bus_rdata` after the next clock edge, whatever the key holds. An unmapped address reads 0x00.
- R9: A write to an unmapped address changes no register and does not raise `write_rejected`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| write_rejected | output | 1 | One-cycle pulse after a dropped protected write |

## Verification
The checker watches every cycle for four properties. A key write lands as written. An accepted timekeeping or power write clears the key. A mismatched protected write produces the reject pulse and leaves the key, the pin configuration and the power register untouched. The pulse never appears unless a write came the cycle before.

Some behaviour shows only at the ports over a sequence of transactions, so the bench's scenarios cover it. These cover the single-shot nature of timekeeping writes, the pin write keeping the key, stored but inert key values, unfiltered reads, and unmapped addresses.

// File: rtl/guard_pkg.sv
package guard_pkg;

  typedef enum logic [1:0] {
    GRP_NONE = 2'd0,
    GRP_PIN  = 2'd1,
    GRP_TIME = 2'd2,
    GRP_PWR  = 2'd3
  } grp_e;

  // slot order: 0 pin config, 1..4 timekeeping, 5 power control
  localparam int NSLOT     = 6;
  localparam int SLOT_PIN  = 0;
  localparam int SLOT_PWR  = 5;

  localparam logic [7:0] UNLOCK_TIME = 8'hEA;
  localparam logic [7:0] UNLOCK_PWR  = 8'hA7;

  function automatic grp_e slot_group(input int idx);
    if (idx == SLOT_PIN)      return GRP_PIN;
    else if (idx == SLOT_PWR) return GRP_PWR;
    else                      return GRP_TIME;
  endfunction

endpackage

// File: rtl/guard_decode.sv
module guard_decode
  import guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int N = NSLOT,
  parameter logic [N-1:0][ADDR_W-1:0] SLOT_ADDRS = '0,
  parameter logic [ADDR_W-1:0] KEY_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              key_hit,
  output logic [N-1:0]      slot_hit,
  output grp_e              grp
);

  assign key_hit = (addr == KEY_ADDR);

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign slot_hit[i] = (addr == SLOT_ADDRS[i]);
  end

  always_comb begin
    grp = GRP_NONE;
    for (int i = 0; i < N; i++) begin
      if (slot_hit[i]) grp = slot_group(i);
    end
  end

endmodule

// File: rtl/guard_key.sv
module guard_key #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              clear,
  output logic [DATA_W-1:0] key_q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     key_q <= '0;
    else if (load)  key_q <= load_val;
    else if (clear) key_q <= '0;
  end

endmodule

// File: rtl/guard_stubs.sv
module guard_stubs #(
  parameter int DATA_W = 8,
  parameter int N = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N-1:0]               we,
  input  logic [DATA_W-1:0]          wdata,
  output logic [N-1:0][DATA_W-1:0]   q
);

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)     q[i] <= '0;
      else if (we[i]) q[i] <= wdata;
    end
  end

endmodule

// File: rtl/reg_write_guard.sv
module reg_write_guard
  import guard_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC1,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 8'hFF,
  parameter logic [ADDR_W-1:0] HSEC_ADDR = 8'hA2,
  parameter logic [ADDR_W-1:0] SEC_ADDR  = 8'hA3,
  parameter logic [ADDR_W-1:0] MIN_ADDR  = 8'hA4,
  parameter logic [ADDR_W-1:0] HOUR_ADDR = 8'hA5,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h87
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              write_rejected
);

  localparam logic [NSLOT-1:0][ADDR_W-1:0] SLOT_ADDRS =
    {PWR_ADDR, HOUR_ADDR, MIN_ADDR, SEC_ADDR, HSEC_ADDR, PIN_ADDR};

  logic                          key_hit;
  logic [NSLOT-1:0]              slot_hit;
  grp_e                          grp;
  logic [DATA_W-1:0]             key_q;
  logic [NSLOT-1:0][DATA_W-1:0]  slot_q;
  logic                          grant;
  logic                          prot_wr;
  logic [NSLOT-1:0]              slot_we;
  logic                          key_clear;
  logic [DATA_W-1:0]             rd_mux;

  guard_decode #(
    .ADDR_W(ADDR_W), .N(NSLOT), .SLOT_ADDRS(SLOT_ADDRS), .KEY_ADDR(KEY_ADDR)
  ) u_dec (
    .addr(bus_addr), .key_hit(key_hit), .slot_hit(slot_hit), .grp(grp)
  );

  always_comb begin
    unique case (grp)
      GRP_PIN, GRP_TIME: grant = (key_q == DATA_W'(UNLOCK_TIME));
      GRP_PWR:           grant = (key_q == DATA_W'(UNLOCK_PWR));
      default:           grant = 1'b0;
    endcase
  end

  assign prot_wr   = bus_wr && (|slot_hit);
  assign slot_we   = (prot_wr && grant) ? slot_hit : '0;
  assign key_clear = prot_wr && grant && (grp == GRP_TIME || grp == GRP_PWR);

  guard_key #(.DATA_W(DATA_W)) u_key (
    .clk(clk), .rst_n(rst_n),
    .load(bus_wr && key_hit), .load_val(bus_wdata),
    .clear(key_clear), .key_q(key_q)
  );

  guard_stubs #(.DATA_W(DATA_W), .N(NSLOT)) u_stubs (
    .clk(clk), .rst_n(rst_n), .we(slot_we), .wdata(bus_wdata), .q(slot_q)
  );

  always_comb begin
    rd_mux = key_hit ? key_q : '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (slot_hit[i]) rd_mux = rd_mux | slot_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata      <= '0;
      write_rejected <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      write_rejected <= prot_wr && !grant;
    end
  end

endmodule

// File: rtl/guard_chk.sv
module guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'hC1,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 8'hFF,
  parameter logic [ADDR_W-1:0] HSEC_ADDR = 8'hA2,
  parameter logic [ADDR_W-1:0] HOUR_ADDR = 8'hA5,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h87
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] key_q,
  input logic [DATA_W-1:0] pin_q,
  input logic [DATA_W-1:0] pwr_q,
  input logic              write_rejected
);

  logic time_addr;
  assign time_addr = (bus_addr >= HSEC_ADDR) && (bus_addr <= HOUR_ADDR);

  // R2
  key_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == KEY_ADDR) |=> key_q == $past(bus_wdata));

  // R4
  time_clears_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && time_addr && key_q == 8'hEA) |=> key_q == '0);

  // R5
  pwr_clears_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PWR_ADDR && key_q == 8'hA7) |=> key_q == '0);

  // R6
  pwr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PWR_ADDR && key_q != 8'hA7)
      |=> (write_rejected && $stable(pwr_q) && $stable(key_q)));

  // R6
  pin_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == PIN_ADDR && key_q != 8'hEA)
      |=> (write_rejected && $stable(pin_q)));

  // R6
  reject_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !write_rejected);

endmodule

bind reg_write_guard guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR), .PIN_ADDR(PIN_ADDR),
  .HSEC_ADDR(HSEC_ADDR), .HOUR_ADDR(HOUR_ADDR), .PWR_ADDR(PWR_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .key_q(key_q), .pin_q(slot_q[0]), .pwr_q(slot_q[5]),
  .write_rejected(write_rejected)
);

// File: tb/sim_reg_write_guard.sv
module sim_reg_write_guard;

  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] A_KEY = 8'hC1, A_PIN = 8'hFF, A_HSEC = 8'hA2,
                         A_SEC = 8'hA3, A_MIN = 8'hA4, A_HOUR = 8'hA5,
                         A_PWR = 8'h87, A_NONE = 8'h10;

  typedef struct {
    bit         is_rd;
    logic [7:0] exp_data;
    bit         exp_rej;
    string      tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic write_rejected;

  int checks = 0;
  int failures = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_write_guard u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .write_rejected(write_rejected)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit rej, input string tag);
    item_t it;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    it.is_rd = 0; it.exp_data = '0; it.exp_rej = rej; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    it.is_rd = 1; it.exp_data = exp; it.exp_rej = 0; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: one bus request per cycle, outputs settle just after the edge
  always @(posedge clk) begin
    if (rst_n && (bus_wr || bus_rd)) begin
      item_t it;
      #1;
      if (sb.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty: unexpected transaction");
      end else begin
        it = sb.pop_front();
        checks++;
        if (write_rejected !== it.exp_rej ||
            (it.is_rd && bus_rdata !== it.exp_data)) begin
          failures++;
          $display("FAIL %s: rdata=%h rej=%b expected rdata=%h rej=%b",
                   it.tag, bus_rdata, write_rejected, it.exp_data, it.exp_rej);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    checks++;
    if (write_rejected !== 1'b0) begin
      failures++;
      $display("FAIL R1: write_rejected=%b expected 0", write_rejected);
    end
    rd(A_KEY, 8'h00, "R1 key after reset");
    rd(A_PIN, 8'h00, "R1 pin after reset");
    rd(A_HSEC, 8'h00, "R1 hsec after reset");
    rd(A_PWR, 8'h00, "R1 pwr after reset");
    wr(A_SEC, 8'h11, 1, "R1 zero key locks time");

    // R2/R3
    wr(A_KEY, 8'hEA, 0, "R2 key write");
    rd(A_KEY, 8'hEA, "R2 key readback");
    wr(A_PIN, 8'h85, 0, "R3 pin write accepted");
    rd(A_PIN, 8'h85, "R3 pin value");
    rd(A_KEY, 8'hEA, "R3 key kept after pin write");

    // R4 single-shot timekeeping
    wr(A_SEC, 8'h30, 0, "R4 sec write accepted");
    rd(A_KEY, 8'h00, "R4 key cleared");
    wr(A_MIN, 8'h12, 1, "R4 second time write rejected");
    rd(A_MIN, 8'h00, "R4 min unchanged");
    wr(A_KEY, 8'hEA, 0, "R4 rekey");
    wr(A_MIN, 8'h12, 0, "R4 min accepted");
    wr(A_KEY, 8'hEA, 0, "R4 rekey");
    wr(A_HOUR, 8'h07, 0, "R4 hour accepted");
    wr(A_KEY, 8'hEA, 0, "R4 rekey");
    wr(A_HSEC, 8'h63, 0, "R4 hsec accepted");
    rd(A_SEC, 8'h30, "R4 sec value");
    rd(A_MIN, 8'h12, "R4 min value");
    rd(A_HOUR, 8'h07, "R4 hour value");
    rd(A_HSEC, 8'h63, "R4 hsec value");

    // R5 power control
    wr(A_KEY, 8'hA7, 0, "R5 power key");
    wr(A_PWR, 8'h5A, 0, "R5 pwr accepted");
    rd(A_KEY, 8'h00, "R5 key cleared");
    rd(A_PWR, 8'h5A, "R5 pwr value");
    wr(A_PWR, 8'h11, 1, "R5 second pwr write rejected");
    rd(A_PWR, 8'h5A, "R5 pwr unchanged");

    // R6 mismatched groups
    wr(A_KEY, 8'hEA, 0, "R6 key EA");
    wr(A_PWR, 8'h22, 1, "R6 EA does not open pwr");
    rd(A_KEY, 8'hEA, "R6 key kept after reject");
    rd(A_PWR, 8'h5A, "R6 pwr unchanged");
    wr(A_KEY, 8'hA7, 0, "R6 key A7");
    wr(A_PIN, 8'h01, 1, "R6 A7 does not open pin");
    wr(A_HOUR, 8'h09, 1, "R6 A7 does not open hour");
    rd(A_PIN, 8'h85, "R6 pin unchanged");
    rd(A_HOUR, 8'h07, "R6 hour unchanged");
    rd(A_KEY, 8'hA7, "R6 key kept");

    // R7 inert key values
    wr(A_KEY, 8'h55, 0, "R7 odd key stored");
    rd(A_KEY, 8'h55, "R7 odd key readback");
    wr(A_SEC, 8'h44, 1, "R7 odd key no time");
    wr(A_PWR, 8'h44, 1, "R7 odd key no pwr");
    wr(A_PIN, 8'h44, 1, "R7 odd key no pin");

    // R8 reads unrestricted while locked
    rd(A_SEC, 8'h30, "R8 sec read with odd key");
    rd(A_NONE, 8'h00, "R8 unmapped read");

    // R9 unmapped write
    wr(A_NONE, 8'hFF, 0, "R9 unmapped write no reject");
    rd(A_NONE, 8'h00, "R9 unmapped still zero");
    rd(A_KEY, 8'h55, "R9 key untouched");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items left", sb.size());
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule